// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block decides when the core, the peripherals and the oscillator of a small 8-bit controller may run. It turns the external reset pin into a qualified internal reset. It parks the CPU in idle or the whole chip in power-down when software asks. It brings the chip back out on an interrupt or on reset. While the chip is in a low-power state it also chooses what the external bus pins show.

Idle stops only the CPU clock. Power-down also stops the oscillator. The way out of power-down goes through a waking state, in which the oscillator runs for a settling interval before anything else proceeds. A reset that arrives during idle lets the CPU run on until the qualified reset takes over, and internal RAM writes are held off for that whole run-on window. The block runs on the raw oscillator clock with an asynchronous power-on clear. RST and all other inputs are assumed synchronous to that clock.

Top module: `lpm_seq`

## Requirements
- R1: `int_rst` rises after `rst_pin` has been sampled high on RST_MC*OSC_PER_MC consecutive clock edges while the oscillator is running. It falls on the first edge at which `rst_pin` is sampled low.
- R2: In run, `pd_req` moves the block to power-down and `idle_req` moves it to idle; `pd_req` wins when both are high. Idle (mode 01) has `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1.
- R3: Idle returns to run (mode 00) on the first edge at which any bit of `irq_pend & irq_en` is set. A pending interrupt whose enable bit is clear leaves the block in idle.
- R4: A `rst_pin` high seen in idle returns to mode 00 with `cpu_clk_en`=1 on the next edge and sets `ram_wr_inhibit`. `ram_wr_inhibit` stays high until the edge after `int_rst` rises.
- R5: Power-down (mode 10) has `osc_en`, `cpu_clk_en` and `periph_clk_en` all 0. Pending interrupts have no effect on it. An external pin that is low but edge-triggered (`ext_int_edge` bit = 1) or not enabled has no effect on it either.
- R6: In power-down, an external pin that is low, enabled and level-triggered moves the block to waking (mode 11) on the next edge, with `osc_en`=1 and `cpu_clk_en`=0.
- R7: Waking returns to run only once STAB_CLKS edges have passed in waking and every enabled, level-triggered external pin is high. A pin held low keeps the block waking for as long as it stays low.
- R8: `rst_pin` high in power-down also enters waking. After the settling interval the reset qualification of R1 starts, and the block reaches run once `int_rst` is high. If `rst_pin` is low by the time settling ends, the block goes back to power-down.
- R9: Pin mux. In run, `pin_ale`, `pin_psen`, `p0_float` and `p2_addr_sel` follow the core inputs. In idle: ALE=1, PSEN=1, and `p0_float` and `p2_addr_sel` equal `ext_code`. In power-down and waking: ALE=0, PSEN=0, `p0_float`=`ext_code`, `p2_addr_sel`=0.
- R10: After `por_n` goes low: mode 00, `int_rst`=0, `ram_wr_inhibit`=0, and all three enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin | input | 1 | External reset pin level |
| idle_req | input | 1 | Software request for idle |
| pd_req | input | 1 | Software request for power-down |
| irq_pend | input | NIRQ | Interrupt pending flags |
| irq_en | input | NIRQ | Interrupt enable flags |
| ext_int_pin | input | 2 | External interrupt pin levels (active low) |
| ext_int_en | input | 2 | External interrupt enables |
| ext_int_edge | input | 2 | 1 = edge-triggered, 0 = level-triggered |
| core_ale | input | 1 | Address latch strobe from the core |
| core_psen | input | 1 | Program read strobe from the core |
| core_p0_float | input | 1 | Core request to float port 0 |
| core_p2_addr | input | 1 | Core request to put address on port 2 |
| ext_code | input | 1 | Code is fetched from external memory |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| mode | output | 2 | 00 run, 01 idle, 10 power-down, 11 waking |
| pin_ale | output | 1 | Address latch strobe at the pin |
| pin_psen | output | 1 | Program read strobe at the pin |
| p0_float | output | 1 | Port 0 drivers off |
| p2_addr_sel | output | 1 | Port 2 shows the address byte |

## Verification
The hardest path to reach from the ports is a reset exit from power-down. It needs a settling interval and then a full qualification window in sequence, and a reset pulse that ends during settling must send the block back to power-down. The bench builds the block with a short settling count so that both outcomes fit in a short run, and it drives the pulse lengths on either side of the boundary. Random pin, enable and trigger-type mixes in power-down, and random pending/enable mixes in idle, cover the wake decisions.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10,
    MODE_WAKE = 2'b11
  } mode_e;

  // clocks of reset hold needed before the internal reset is granted
  function automatic int unsigned hold_clks(input int unsigned mcs, input int unsigned per_mc);
    return mcs * per_mc;
  endfunction

  // an external pin requests a power-down exit: enabled, level type, low
  function automatic logic wake_level_low(input logic [1:0] pin, input logic [1:0] en,
                                          input logic [1:0] edge_type);
    return |(en & ~edge_type & ~pin);
  endfunction

endpackage

// File: rtl/lpm_hold_timer.sv
module lpm_hold_timer #(
  parameter int unsigned LIMIT = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic clear,
  input  logic count_en,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  assign done = (cnt == LIM);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (count_en && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned NIRQ = 5
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_pin,
  input  logic            int_rst,
  input  logic            idle_req,
  input  logic            pd_req,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            lvl_low,
  input  logic            stab_done,
  output mode_e           state,
  output logic            run_on
);
  mode_e nstate;
  logic  nrun_on, by_rst, nby_rst, irq_hit;

  assign irq_hit = |(irq_pend & irq_en);

  always_comb begin
    nstate  = state;
    nrun_on = run_on;
    nby_rst = by_rst;
    if (int_rst) begin
      nstate  = MODE_RUN;
      nrun_on = 1'b0;
      nby_rst = 1'b0;
    end else begin
      case (state)
        MODE_RUN: begin
          if (!rst_pin) nrun_on = 1'b0;
          if (pd_req)        nstate = MODE_PD;
          else if (idle_req) nstate = MODE_IDLE;
        end
        MODE_IDLE: begin
          if (rst_pin) begin
            nstate  = MODE_RUN;
            nrun_on = 1'b1;
          end else if (irq_hit) begin
            nstate = MODE_RUN;
          end
        end
        MODE_PD: begin
          if (rst_pin) begin
            nstate  = MODE_WAKE;
            nby_rst = 1'b1;
          end else if (lvl_low) begin
            nstate  = MODE_WAKE;
            nby_rst = 1'b0;
          end
        end
        default: begin
          if (rst_pin) nby_rst = 1'b1;
          if (stab_done) begin
            if (by_rst && !rst_pin)
              nstate = MODE_PD;
            else if (!by_rst && !rst_pin && !lvl_low)
              nstate = MODE_RUN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= MODE_RUN;
      run_on <= 1'b0;
      by_rst <= 1'b0;
    end else begin
      state  <= nstate;
      run_on <= nrun_on;
      by_rst <= nby_rst;
    end
  end
endmodule

// File: rtl/lpm_port_mux.sv
module lpm_port_mux
  import lpm_pkg::*;
(
  input  mode_e state,
  input  logic  core_ale,
  input  logic  core_psen,
  input  logic  core_p0_float,
  input  logic  core_p2_addr,
  input  logic  ext_code,
  output logic  pin_ale,
  output logic  pin_psen,
  output logic  p0_float,
  output logic  p2_addr_sel
);
  always_comb begin
    case (state)
      MODE_RUN: begin
        pin_ale     = core_ale;
        pin_psen    = core_psen;
        p0_float    = core_p0_float;
        p2_addr_sel = core_p2_addr;
      end
      MODE_IDLE: begin
        pin_ale     = 1'b1;
        pin_psen    = 1'b1;
        p0_float    = ext_code;
        p2_addr_sel = ext_code;
      end
      default: begin
        pin_ale     = 1'b0;
        pin_psen    = 1'b0;
        p0_float    = ext_code;
        p2_addr_sel = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned NIRQ       = 5,
  parameter int unsigned OSC_PER_MC = 12,
  parameter int unsigned RST_MC     = 2,
  parameter int unsigned STAB_CLKS  = 240000
) (
  input  logic            clk_osc,
  input  logic            por_n,
  input  logic            rst_pin,
  input  logic            idle_req,
  input  logic            pd_req,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [1:0]      ext_int_pin,
  input  logic [1:0]      ext_int_en,
  input  logic [1:0]      ext_int_edge,
  input  logic            core_ale,
  input  logic            core_psen,
  input  logic            core_p0_float,
  input  logic            core_p2_addr,
  input  logic            ext_code,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            osc_en,
  output logic            int_rst,
  output logic            ram_wr_inhibit,
  output logic [1:0]      mode,
  output logic            pin_ale,
  output logic            pin_psen,
  output logic            p0_float,
  output logic            p2_addr_sel
);
  localparam int unsigned RST_CLKS = hold_clks(RST_MC, OSC_PER_MC);

  mode_e state;
  logic  run_on, stab_done, osc_stable, lvl_low, in_wake;

  assign lvl_low    = wake_level_low(ext_int_pin, ext_int_en, ext_int_edge);
  assign in_wake    = (state == MODE_WAKE);
  assign osc_stable = (state == MODE_RUN) || (state == MODE_IDLE) || (in_wake && stab_done);

  lpm_hold_timer #(.LIMIT(RST_CLKS)) u_rst_qual (
    .clk(clk_osc), .por_n(por_n), .clear(!rst_pin), .count_en(osc_stable), .done(int_rst)
  );

  lpm_hold_timer #(.LIMIT(STAB_CLKS)) u_stab (
    .clk(clk_osc), .por_n(por_n), .clear(!in_wake), .count_en(1'b1), .done(stab_done)
  );

  lpm_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk(clk_osc), .por_n(por_n), .rst_pin(rst_pin), .int_rst(int_rst),
    .idle_req(idle_req), .pd_req(pd_req), .irq_pend(irq_pend), .irq_en(irq_en),
    .lvl_low(lvl_low), .stab_done(stab_done), .state(state), .run_on(run_on)
  );

  lpm_port_mux u_mux (
    .state(state), .core_ale(core_ale), .core_psen(core_psen),
    .core_p0_float(core_p0_float), .core_p2_addr(core_p2_addr), .ext_code(ext_code),
    .pin_ale(pin_ale), .pin_psen(pin_psen), .p0_float(p0_float), .p2_addr_sel(p2_addr_sel)
  );

  assign mode           = state;
  assign cpu_clk_en     = (state == MODE_RUN);
  assign periph_clk_en  = (state == MODE_RUN) || (state == MODE_IDLE);
  assign osc_en         = (state != MODE_PD);
  assign ram_wr_inhibit = run_on;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_pin,
  input logic       int_rst,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       ram_wr_inhibit,
  input logic       stab_done
);
  a_r1_rst_follows_pin: assert property (@(posedge clk) disable iff (!por_n)
    $rose(int_rst) |-> $past(rst_pin));

  a_r2_idle_cpu_only: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b01) |-> (!cpu_clk_en && periph_clk_en && osc_en));

  a_r4_inhibit_in_run: assert property (@(posedge clk) disable iff (!por_n)
    ram_wr_inhibit |-> (mode == 2'b00 && cpu_clk_en));

  a_r5_pd_all_stopped: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b10) |-> (!osc_en && !cpu_clk_en && !periph_clk_en));

  a_r6_wake_osc_only: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b11) |-> (osc_en && !cpu_clk_en));

  a_r7_wake_holds: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b11 && !stab_done) |=> (mode == 2'b11));

  a_r8_pd_leaves_to_wake: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b10) |=> (mode == 2'b10 || mode == 2'b11));
endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk_osc), .por_n(por_n), .rst_pin(rst_pin), .int_rst(int_rst), .mode(mode),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
  .ram_wr_inhibit(ram_wr_inhibit), .stab_done(stab_done)
);

// File: tb/test_lpm_seq.sv
module test_lpm_seq;
  localparam int CLK_P = 10;
  localparam int NIRQ  = 5;
  localparam int OPM   = 12;
  localparam int RMC   = 2;
  localparam int STAB  = 40;
  localparam int RCLK  = OPM * RMC;

  logic clk = 1'b0;
  logic por_n, rst_pin, idle_req, pd_req;
  logic [NIRQ-1:0] irq_pend, irq_en;
  logic [1:0] ext_int_pin, ext_int_en, ext_int_edge;
  logic core_ale, core_psen, core_p0_float, core_p2_addr, ext_code;
  logic cpu_clk_en, periph_clk_en, osc_en, int_rst, ram_wr_inhibit;
  logic [1:0] mode;
  logic pin_ale, pin_psen, p0_float, p2_addr_sel;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  lpm_seq #(.NIRQ(NIRQ), .OSC_PER_MC(OPM), .RST_MC(RMC), .STAB_CLKS(STAB)) i_lpm_seq (
    .clk_osc(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .ext_int_pin(ext_int_pin), .ext_int_en(ext_int_en),
    .ext_int_edge(ext_int_edge), .core_ale(core_ale), .core_psen(core_psen),
    .core_p0_float(core_p0_float), .core_p2_addr(core_p2_addr), .ext_code(ext_code),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .int_rst(int_rst), .ram_wr_inhibit(ram_wr_inhibit), .mode(mode),
    .pin_ale(pin_ale), .pin_psen(pin_psen), .p0_float(p0_float), .p2_addr_sel(p2_addr_sel)
  );

  function automatic bit exp_idle_exit(input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e);
    for (int i = 0; i < NIRQ; i++) if (p[i] && e[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_pd_wake(input logic [1:0] pin, input logic [1:0] en,
                                     input logic [1:0] et);
    for (int i = 0; i < 2; i++) if (en[i] && !et[i] && !pin[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic back_to_run();
    if (mode == 2'b01) begin
      irq_pend = 1; irq_en = 1; tick(); irq_pend = 0; irq_en = 0;
    end else if (mode == 2'b10) begin
      ext_int_en = 2'b01; ext_int_edge = 2'b00; ext_int_pin = 2'b10; tick();
    end
    ext_int_pin = 2'b11;
    for (int k = 0; k < STAB + 6 && mode != 2'b00; k++) tick();
    ext_int_en = 2'b00; ext_int_edge = 2'b00;
    check("R6 return to run", {30'd0, mode}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NIRQ-1:0] rp, re;
    logic [1:0] rpin, ren, ret;
    logic [3:0] rc;
    void'($urandom(32'd1357));
    por_n = 0; rst_pin = 0; idle_req = 0; pd_req = 0; irq_pend = 0; irq_en = 0;
    ext_int_pin = 2'b11; ext_int_en = 0; ext_int_edge = 0;
    core_ale = 0; core_psen = 0; core_p0_float = 0; core_p2_addr = 0; ext_code = 0;
    #(3*CLK_P);
    tick(); por_n = 1; tick();

    // R10 reset state
    check("R10 mode", {30'd0, mode}, 0);
    check("R10 int_rst", int_rst, 0);
    check("R10 enables", {cpu_clk_en, periph_clk_en, osc_en, ram_wr_inhibit}, 4'b1110);

    // R1 reset qualification in run
    rst_pin = 1;
    repeat (RCLK - 1) tick();
    check("R1 not yet", int_rst, 0);
    tick();
    check("R1 asserted", int_rst, 1);
    rst_pin = 0; tick();
    check("R1 released", int_rst, 0);

    // R2 priority and idle state
    idle_req = 1; pd_req = 1; tick(); idle_req = 0; pd_req = 0;
    check("R2 pd wins", {30'd0, mode}, 2);
    back_to_run();
    idle_req = 1; tick(); idle_req = 0;
    check("R2 idle mode", {30'd0, mode}, 1);
    check("R2 idle enables", {cpu_clk_en, periph_clk_en, osc_en}, 3'b011);

    // R9 idle pin mux
    ext_code = 1; #1;
    check("R9 idle ext", {pin_ale, pin_psen, p0_float, p2_addr_sel}, 4'b1111);
    ext_code = 0; #1;
    check("R9 idle int", {pin_ale, pin_psen, p0_float, p2_addr_sel}, 4'b1100);

    // R3 pending without enable is ignored
    irq_pend = '1; irq_en = '0; tick();
    check("R3 disabled ignored", {30'd0, mode}, 1);
    irq_pend = 0;
    for (int n = 0; n < 30; n++) begin
      rp = NIRQ'($urandom); re = NIRQ'($urandom);
      if (n == 0) begin rp = 5'b00100; re = 5'b01011; end
      irq_pend = rp; irq_en = re; tick();
      check("R3 idle exit", {30'd0, mode}, exp_idle_exit(rp, re) ? 0 : 1);
      irq_pend = 0; irq_en = 0;
      if (mode == 2'b00) begin idle_req = 1; tick(); idle_req = 0; end
    end

    // R4 reset during idle: run-on with RAM write block
    rst_pin = 1; tick();
    check("R4 run-on mode", {30'd0, mode}, 0);
    check("R4 run-on cpu and inhibit", {cpu_clk_en, ram_wr_inhibit}, 2'b11);
    repeat (RCLK - 2) tick();
    check("R4 inhibit held", {int_rst, ram_wr_inhibit}, 2'b01);
    tick();
    check("R4 int_rst up", int_rst, 1);
    tick();
    check("R4 inhibit cleared", ram_wr_inhibit, 0);
    rst_pin = 0; tick();

    // R5 power-down
    pd_req = 1; tick(); pd_req = 0;
    check("R5 pd mode", {30'd0, mode}, 2);
    check("R5 pd enables", {cpu_clk_en, periph_clk_en, osc_en}, 3'b000);
    ext_code = 1; #1;
    check("R9 pd mux", {pin_ale, pin_psen, p0_float, p2_addr_sel}, 4'b0010);
    ext_code = 0;
    irq_pend = '1; irq_en = '1; tick();
    check("R5 irq ignored", {30'd0, mode}, 2);
    irq_pend = 0; irq_en = 0;
    ext_int_en = 2'b01; ext_int_edge = 2'b01; ext_int_pin = 2'b10; tick();
    check("R5 edge pin ignored", {30'd0, mode}, 2);
    ext_int_en = 2'b00; ext_int_edge = 2'b00; ext_int_pin = 2'b00; tick();
    check("R5 disabled pin ignored", {30'd0, mode}, 2);
    ext_int_pin = 2'b11;

    for (int n = 0; n < 16; n++) begin
      rpin = 2'($urandom); ren = 2'($urandom); ret = 2'($urandom);
      ext_int_pin = rpin; ext_int_en = ren; ext_int_edge = ret; tick();
      check("R6 pd wake decision", {30'd0, mode}, exp_pd_wake(rpin, ren, ret) ? 3 : 2);
      back_to_run();
      pd_req = 1; tick(); pd_req = 0;
    end

    // R6/R7 interrupt exit, pin back high early
    ext_int_en = 2'b10; ext_int_edge = 2'b00; ext_int_pin = 2'b01; tick();
    check("R6 wake mode", {30'd0, mode}, 3);
    check("R6 wake enables", {cpu_clk_en, osc_en}, 2'b01);
    ext_int_pin = 2'b11;
    repeat (STAB) tick();
    check("R7 still settling", {30'd0, mode}, 3);
    tick();
    check("R6 exit complete", {30'd0, mode}, 0);

    // R7 pin held low beyond settling
    pd_req = 1; tick(); pd_req = 0;
    ext_int_pin = 2'b01; tick();
    repeat (STAB + 5) tick();
    check("R7 held low", {30'd0, mode}, 3);
    ext_int_pin = 2'b11; tick();
    check("R7 released", {30'd0, mode}, 0);
    ext_int_en = 0;

    // R8 reset exit from power-down
    pd_req = 1; tick(); pd_req = 0;
    rst_pin = 1; tick();
    check("R8 wake on reset", {30'd0, mode}, 3);
    repeat (STAB) tick();
    check("R8 no reset during settle", int_rst, 0);
    repeat (RCLK) tick();
    check("R8 int_rst after settle", {int_rst, mode}, 3'b111);
    tick();
    check("R8 run after reset", {30'd0, mode}, 0);
    rst_pin = 0; tick();
    check("R8 reset released", int_rst, 0);

    // R8 short reset pulse returns to power-down
    pd_req = 1; tick(); pd_req = 0;
    rst_pin = 1; tick(); rst_pin = 0;
    repeat (STAB) tick();
    check("R8 short pulse settling", {30'd0, mode}, 3);
    tick();
    check("R8 short pulse back to pd", {30'd0, mode}, 2);
    back_to_run();

    // R9 run pass-through
    for (int n = 0; n < 8; n++) begin
      rc = 4'($urandom);
      {core_ale, core_psen, core_p0_float, core_p2_addr} = rc; #1;
      check("R9 run pass", {pin_ale, pin_psen, p0_float, p2_addr_sel}, rc);
      tick();
    end

    finish_run();
  end
endmodule